// File: doc/BRIEF.md
# External Clock Failure Monitor

This block watches a fast external oscillator clock from the point of view of an internal reference clock that never stops. Every rising edge of the watched clock flips a toggle flop in the watched domain. That toggle is carried into the reference domain through a synchronizer chain, and each change of the synchronized toggle counts as one observed edge. A gap counter in the reference domain measures how many consecutive reference cycles pass with no observed edge. When the gap reaches `TIMEOUT_CYCLES`, the oscillator is declared dead. The block checks only for a clock that has stopped; it does not judge frequency accuracy.

Software supplies two enables: one for the monitor and one that requests the oscillator. The oscillator start-up logic supplies a ready indication. The monitor arms only once the oscillator reports ready, and it drops back to idle as soon as the oscillator request or ready indication goes away.

On a failure the block does three things:
- It raises a disable output that forces the oscillator off.
- It sends a one-cycle break pulse to the brake inputs of two timer units.
- It sets a sticky flag that drives a non-maskable interrupt. The flag stays set until software clears it.

The controller is a four-state machine:
- `ST_OFF` (idle) moves to `ST_WAIT_RDY` when both enables are high.
- `ST_WAIT_RDY` returns to `ST_OFF` if either enable drops, and moves to `ST_ARMED` when ready rises.
- `ST_ARMED` returns to `ST_OFF` if either enable or ready drops. It moves to `ST_TRIPPED` when the gap counter expires; this transition is the trip event.
- `ST_TRIPPED` returns to `ST_OFF` when software withdraws the oscillator request.

Top module: `xosc_fail_monitor`

## Requirements
- R1: After reset, `osc_kill`, `brk_pulse` and `nmi_flag` are all 0.
- R2: While `osc_rdy` is 0, no failure is declared, even if the watched clock never toggles.
- R3: While `mon_en` is 0 or `osc_on` is 0, no failure is declared, even if the watched clock is stopped.
- R4: With the monitor armed, a watched clock whose rising edges are at most `TIMEOUT_CYCLES`-1 reference cycles apart never causes a failure (tested with periods of 3 and 7 reference cycles).
- R5: With the monitor armed, if the watched clock stops, a failure is declared. `osc_kill`, `brk_pulse` and `nmi_flag` all rise together, between `TIMEOUT_CYCLES` and `TIMEOUT_CYCLES`+10 reference cycles after the clock is stopped. A gap of 20 reference cycles also trips.
- R6: `brk_pulse` is high for exactly one reference cycle per failure event.
- R7: Once set, `osc_kill` stays 1 while `osc_on` is 1, even if `osc_rdy` falls. It drops one cycle after `osc_on` goes to 0. A new request with ready re-arms the monitor, and a later stop trips it again.
- R8: `nmi_flag` stays 1 after `osc_kill` is released. It goes to 0 on the cycle after `flag_clr` is 1.
- R9: `flag_clr` has no effect while `nmi_flag` is 0. While the failure is ongoing (`osc_kill` = 1), `flag_clr` does not clear `nmi_flag`.
- R10: Dropping `osc_rdy` or `mon_en` while armed disarms the monitor, so a clock that stops at the same moment causes no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | 1 | Watched external oscillator clock |
| mon_en | input | 1 | Software enable of the monitor |
| osc_on | input | 1 | Software request that the oscillator runs |
| osc_rdy | input | 1 | Oscillator start-up complete |
| flag_clr | input | 1 | Software clear of the failure flag |
| osc_kill | output | 1 | Forces the oscillator disabled after a failure |
| brk_pulse | output | 1 | One-cycle break pulse to two timer units |
| nmi_flag | output | 1 | Sticky failure flag driving the non-maskable interrupt |

## Verification
The assertions assume that the enables, ready and clear are synchronous to `ref_clk`. They also assume that the watched clock's edges arrive no faster than the synchronizer can carry the toggle, which means a watched period of at least two reference cycles. The bench drives every control input on falling reference edges. It runs the watched clock at periods of 3, 7 and 20 reference cycles, or holds it low, so every observed edge corresponds to exactly one watched rising edge. Trip timing is checked against a window rather than a single cycle, because the phase between the two clocks is free.

// File: rtl/xfm_pkg.sv
`timescale 1ns/1ps
package xfm_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WAIT_RDY = 2'd1,
        ST_ARMED    = 2'd2,
        ST_TRIPPED  = 2'd3
    } mon_state_t;
endpackage

// File: rtl/xfm_edge_sync.sv
`timescale 1ns/1ps
// Carries each watched rising edge into the reference domain as a one-cycle pulse.
module xfm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic rise_seen
);
    logic                   tog_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tog_q;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise_seen = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/xfm_gap_counter.sv
`timescale 1ns/1ps
// Counts reference cycles since the last observed edge while running.
module xfm_gap_counter #(
    parameter int TIMEOUT_CYCLES = 8
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise_seen,
    output logic starved
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                 gap_q <= '0;
        else if (!run || rise_seen) gap_q <= '0;
        else if (gap_q != LIMIT)    gap_q <= gap_q + 1'b1;
    end

    assign starved = run && !rise_seen && (gap_q == LIMIT);

    // R4: an observed edge always restarts the gap measurement
    a_r4_edge_restarts: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (run && rise_seen) |=> (gap_q == '0));
endmodule

// File: rtl/xosc_fail_monitor.sv
`timescale 1ns/1ps
module xosc_fail_monitor #(
    parameter int TIMEOUT_CYCLES = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic mon_en,
    input  logic osc_on,
    input  logic osc_rdy,
    input  logic flag_clr,
    output logic osc_kill,
    output logic brk_pulse,
    output logic nmi_flag
);
    import xfm_pkg::*;

    mon_state_t state_q, state_d;
    logic       rise_seen;
    logic       starved;
    logic       armed;
    logic       trip_evt;
    logic       req_ok;

    xfm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .mon_clk   (mon_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .rise_seen (rise_seen)
    );

    assign armed = (state_q == ST_ARMED);

    xfm_gap_counter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) gap_i (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .run       (armed),
        .rise_seen (rise_seen),
        .starved   (starved)
    );

    assign req_ok = mon_en && osc_on;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:      if (req_ok) state_d = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (!req_ok)      state_d = ST_OFF;
                else if (osc_rdy) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!(req_ok && osc_rdy)) state_d = ST_OFF;
                else if (starved)         state_d = ST_TRIPPED;
            end
            ST_TRIPPED:  if (!osc_on) state_d = ST_OFF;
            default:     state_d = ST_OFF;
        endcase
    end

    assign trip_evt = (state_q == ST_ARMED) && (state_d == ST_TRIPPED);

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_kill  <= 1'b0;
            brk_pulse <= 1'b0;
            nmi_flag  <= 1'b0;
        end else begin
            osc_kill  <= (state_d == ST_TRIPPED);
            brk_pulse <= trip_evt;
            if (state_d == ST_TRIPPED) nmi_flag <= 1'b1;
            else if (flag_clr)         nmi_flag <= 1'b0;
        end
    end

    // R2 R3 R10: a break only follows a cycle with monitor, request and ready all high
    a_r3_break_needs_arm: assert property (@(posedge ref_clk) disable iff (!rst_n)
        brk_pulse |-> $past(mon_en && osc_on && osc_rdy));

    // R6: break lasts a single cycle
    a_r6_break_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    // R5: break comes with the disable and the flag
    a_r5_trip_outputs: assert property (@(posedge ref_clk) disable iff (!rst_n)
        brk_pulse |-> (osc_kill && nmi_flag));

    // R7: disable holds while the oscillator is still requested
    a_r7_kill_holds: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (osc_kill && osc_on) |=> osc_kill);

    // R8: flag is sticky without a clear
    a_r8_flag_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (nmi_flag && !flag_clr) |=> nmi_flag);

    // R9: flag rises only with a failure event, never through a clear
    a_r9_flag_rise_cause: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(nmi_flag) |-> brk_pulse);
endmodule

// File: tb/xosc_fail_monitor_tb_top.sv
`timescale 1ns/1ps
module xosc_fail_monitor_tb_top;
    localparam int TMO = 8;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic mon_en = 1'b0, osc_on = 1'b0, osc_rdy = 1'b0, flag_clr = 1'b0;
    logic osc_kill, brk_pulse, nmi_flag;

    logic mon_run = 1'b0;
    int   mon_half = 15;
    int   total = 0, fails = 0;
    bit   done = 1'b0;

    xosc_fail_monitor #(.TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2)) dut_i (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk),
        .mon_en(mon_en), .osc_on(osc_on), .osc_rdy(osc_rdy), .flag_clr(flag_clr),
        .osc_kill(osc_kill), .brk_pulse(brk_pulse), .nmi_flag(nmi_flag)
    );

    always #5 ref_clk = ~ref_clk;

    initial begin
        forever begin
            if (mon_run) begin
                #(mon_half) mon_clk = ~mon_clk;
            end else begin
                mon_clk = 1'b0;
                #1;
            end
        end
    end

    // Vector fields: [16:13] requirement, [12] mon_en, [11] osc_on, [10] osc_rdy,
    // [9] watched clock running, [8] failure expected, [7:0] half period in ns
    localparam logic [16:0] VECS [0:6] = '{
        {4'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd15},   // R4 period 3 cycles
        {4'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd35},   // R4 period 7 cycles
        {4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd100},  // R5 gap 20 cycles
        {4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd15},   // R5 stopped clock
        {4'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd15},   // R3 monitor disabled
        {4'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd15},   // R3 oscillator not requested
        {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd15}    // R2 never ready
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic do_reset();
        @(negedge ref_clk);
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        cyc(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        int brks;

        // R1: reset state
        do_reset();
        chk("R1 osc_kill", osc_kill, 1'b0);
        chk("R1 brk_pulse", brk_pulse, 1'b0);
        chk("R1 nmi_flag", nmi_flag, 1'b0);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            mon_run = 1'b0;
            mon_en = 1'b0; osc_on = 1'b0; osc_rdy = 1'b0;
            do_reset();
            mon_half = int'(VECS[i][7:0]);
            mon_en   = VECS[i][12];
            osc_on   = VECS[i][11];
            osc_rdy  = VECS[i][10];
            mon_run  = VECS[i][9];
            cyc(80);
            chk($sformatf("R%0d vec%0d osc_kill", VECS[i][16:13], i), osc_kill, VECS[i][8]);
            chk($sformatf("R%0d vec%0d nmi_flag", VECS[i][16:13], i), nmi_flag, VECS[i][8]);
        end

        // R5 R6: trip timing and single break pulse
        mon_run = 1'b0;
        mon_en = 1'b0; osc_on = 1'b0; osc_rdy = 1'b0;
        do_reset();
        mon_half = 15;
        mon_run = 1'b1;
        mon_en = 1'b1; osc_on = 1'b1; osc_rdy = 1'b1;
        cyc(30);
        chk("R4 running no trip", osc_kill, 1'b0);
        mon_run = 1'b0;
        n = 0;
        while (!osc_kill && n < 40) begin
            cyc(1);
            n++;
        end
        chk($sformatf("R5 trip window n=%0d", n), (n >= TMO) && (n <= TMO + 10), 1'b1);
        chk("R6 break high at trip", brk_pulse, 1'b1);
        chk("R5 flag at trip", nmi_flag, 1'b1);
        cyc(1);
        chk("R6 break one cycle", brk_pulse, 1'b0);

        // R7: kill holds with ready dropped; R9: clear overridden during failure
        osc_rdy = 1'b0;
        cyc(5);
        chk("R7 kill holds without ready", osc_kill, 1'b1);
        pulse_clr();
        chk("R9 clear overridden during failure", nmi_flag, 1'b1);
        osc_on = 1'b0;
        cyc(2);
        chk("R7 kill released", osc_kill, 1'b0);
        chk("R8 flag survives release", nmi_flag, 1'b1);
        pulse_clr();
        chk("R8 flag cleared", nmi_flag, 1'b0);
        pulse_clr();
        chk("R9 clear idle flag", nmi_flag, 1'b0);
        chk("R9 clear idle kill", osc_kill, 1'b0);
        chk("R9 clear idle break", brk_pulse, 1'b0);

        // R7: re-arm and trip again, R6 count breaks
        mon_run = 1'b1;
        osc_on = 1'b1; osc_rdy = 1'b1;
        cyc(40);
        chk("R7 rearmed running no trip", osc_kill, 1'b0);
        mon_run = 1'b0;
        brks = 0;
        for (int k = 0; k < 40; k++) begin
            cyc(1);
            if (brk_pulse) brks++;
        end
        chk("R7 retrip", osc_kill, 1'b1);
        chk($sformatf("R6 break count=%0d", brks), brks == 1, 1'b1);

        // R10: ready withdrawn together with clock stop
        osc_on = 1'b0;
        cyc(2);
        pulse_clr();
        mon_run = 1'b1;
        osc_on = 1'b1; osc_rdy = 1'b1;
        cyc(30);
        mon_run = 1'b0;
        osc_rdy = 1'b0;
        cyc(40);
        chk("R10 ready drop disarms", osc_kill, 1'b0);
        chk("R10 ready drop no flag", nmi_flag, 1'b0);

        // R10: monitor enable withdrawn together with clock stop
        mon_run = 1'b1;
        osc_rdy = 1'b1;
        cyc(30);
        mon_run = 1'b0;
        mon_en = 1'b0;
        cyc(40);
        chk("R10 enable drop disarms", osc_kill, 1'b0);
        chk("R10 enable drop no flag", nmi_flag, 1'b0);

        finish_run();
    end
endmodule